// File: doc/BRIEF.md
# Fractional Baud Oversampling Enable Generator

This block turns a free-running system clock into the one-cycle oversampling strobe that a serial receiver or transmitter uses. That strobe normally runs at sixteen times the bit rate. Often the clock is not an integer multiple of sixteen times the bit rate. A single integer divisor then leaves a rate error that a far-end receiver may not tolerate. For example, dividing a 62.5 MHz clock by 33 misses 115200 bit/s by almost three percent. To avoid this, the block takes a divisor in two parts: an integer interval length N and a fractional numerator f, counted in units of 2^FRAC_W. Each strobe adds f to a fractional accumulator. A carry out of the accumulator lengthens the next interval by one clock. The gaps between strobes therefore dither between N and N+1 clocks, and their long-run mean equals N + f/2^FRAC_W.

A second output marks every OVS-th strobe and serves as a once-per-bit enable. The divisor inputs are taken only where an interval ends, so software or a neighbouring block may change them at any time without producing a short or merged strobe. Reset clears the interval counter, the accumulator and the strobe count.

Top module: `baud_frac_tick_gen`

## Requirements
- R1: While rst is high, neither os_tick nor bit_tick is asserted, and reset clears the interval counter, the fractional accumulator and the strobe count.
- R2: After the last clock edge with rst high, the first os_tick appears after N-1 further edges, so the first interval is exactly N clocks with no stretch.
- R3: Every gap between two consecutive os_tick pulses is N or N+1 clocks. It is N+1 exactly when the FRAC_W-bit accumulator, which adds f at each os_tick, overflowed at the os_tick that opened the gap.
- R4: Counting from reset with N and f held constant, the j-th os_tick falls on edge j*N + floor((j-1)*f / 2^FRAC_W) - 1, so the mean period over any 16 bit periods is within one clock of the programmed ratio.
- R5: With N = 13 and f = 2^(FRAC_W-1), the gaps alternate 13, 14, 13, 14, starting with 13, which gives two strobes in every 27-clock frame.
- R6: With f = 0, every gap is exactly N clocks, as with a plain integer divisor.
- R7: An integer divisor of 0 or 1 is treated as 2, so os_tick is never high on two adjacent clocks.
- R8: div_int and div_frac are taken only at an os_tick edge or during reset. A change in the middle of an interval leaves that interval's length unchanged and takes effect from the next interval.
- R9: bit_tick is high only together with os_tick, on the OVS-th, 2*OVS-th, and so on, os_tick after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_int | input | DIV_W | Integer interval length N in clocks (values below 2 act as 2) |
| div_frac | input | FRAC_W | Fractional numerator f, in units of 2^-FRAC_W clock |
| os_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle enable on every OVS-th os_tick (tied low when BIT_TICK_EN = 0) |

## Verification
The properties assume that rst is synchronous and is high from time zero for at least two clock edges. They also assume that strobes and bit counts are measured from the most recent reset. The stimulus holds reset for several cycles at the start and before every scenario. It changes div_int and div_frac only on the falling clock edge. It uses out-of-range integer divisors only in the scenario that checks clamping. Because the adjacency and bit-alignment properties hold for every divisor value, mid-interval divisor changes stay inside their assumptions.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;

   // Shortest interval the generator will produce, in clocks.
   localparam int unsigned LEN_FLOOR = 2;

   // Bits needed to count 0 .. n-1, never less than one.
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/baud_div_sampler.sv
module baud_div_sampler
   import baud_frac_pkg::*;
#(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned FRAC_W = 8,
   localparam int unsigned LEN_W = DIV_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DIV_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic              carry,
   output logic [LEN_W-1:0]  len_q,
   output logic [FRAC_W-1:0] frac_q
);

   logic [LEN_W-1:0] base_len;

   // Clamp the integer part so an interval never shrinks below LEN_FLOOR.
   assign base_len = (div_int < DIV_W'(LEN_FLOOR)) ? LEN_W'(LEN_FLOOR)
                                                   : {1'b0, div_int};

   always_ff @(posedge clk) begin
      if (rst) begin
         len_q  <= base_len;
         frac_q <= div_frac;
      end else if (load) begin
         len_q  <= base_len + LEN_W'(carry);
         frac_q <= div_frac;
      end
   end

endmodule

// File: rtl/baud_frac_accum.sv
module baud_frac_accum #(
   parameter int unsigned FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic [FRAC_W-1:0] frac,
   output logic              carry
);

   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;

   assign sum   = {1'b0, acc_q} + {1'b0, frac};
   assign carry = sum[FRAC_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (step) begin
         acc_q <= sum[FRAC_W-1:0];
      end
   end

endmodule

// File: rtl/baud_ivl_counter.sv
module baud_ivl_counter #(
   parameter int unsigned LEN_W = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LEN_W-1:0] len,
   output logic             tick
);

   logic [LEN_W-1:0] cnt_q;

   assign tick = (cnt_q == (len - LEN_W'(1)));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + LEN_W'(1);
      end
   end

endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter
   import baud_frac_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter bit          BIT_TICK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic os_tick,
   output logic bit_tick
);

   localparam int unsigned SUB_W = cnt_bits(OVS);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

   generate
      if (BIT_TICK_EN) begin : g_bit
         logic [SUB_W-1:0] sub_q;

         assign bit_tick = os_tick && (sub_q == SUB_LAST);

         always_ff @(posedge clk) begin
            if (rst) begin
               sub_q <= '0;
            end else if (os_tick) begin
               sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
            end
         end
      end else begin : g_nobit
         logic unused_bits;
         assign unused_bits = ^{clk, rst, os_tick};
         assign bit_tick    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/baud_frac_tick_gen.sv
module baud_frac_tick_gen #(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned FRAC_W      = 8,
   parameter int unsigned OVS         = 16,
   parameter bit          BIT_TICK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              os_tick,
   output logic              bit_tick
);

   localparam int unsigned LEN_W = DIV_W + 1;

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("baud_frac_tick_gen: DIV_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("baud_frac_tick_gen: FRAC_W must be at least 1");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("baud_frac_tick_gen: OVS must be at least 2");
      end
   endgenerate

   logic              tick_raw;
   logic              carry;
   logic [LEN_W-1:0]  len_q;
   logic [FRAC_W-1:0] frac_q;

   baud_div_sampler #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_smp (
      .clk      (clk),
      .rst      (rst),
      .load     (tick_raw),
      .div_int  (div_int),
      .div_frac (div_frac),
      .carry    (carry),
      .len_q    (len_q),
      .frac_q   (frac_q)
   );

   baud_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .step  (tick_raw),
      .frac  (frac_q),
      .carry (carry)
   );

   baud_ivl_counter #(.LEN_W(LEN_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .len  (len_q),
      .tick (tick_raw)
   );

   assign os_tick = tick_raw & ~rst;

   baud_bit_counter #(.OVS(OVS), .BIT_TICK_EN(BIT_TICK_EN)) u_bit (
      .clk      (clk),
      .rst      (rst),
      .os_tick  (os_tick),
      .bit_tick (bit_tick)
   );

endmodule

// File: rtl/baud_frac_tick_gen_chk.sv
module baud_frac_tick_gen_chk #(
   parameter int unsigned OVS         = 16,
   parameter bit          BIT_TICK_EN = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic os_tick,
   input logic bit_tick
);

   localparam int unsigned CT_W = (OVS <= 2) ? 1 : $clog2(OVS);

   logic            rst_q;
   logic [CT_W-1:0] seen_ct;

   always_ff @(posedge clk) begin
      rst_q <= rst;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_ct <= '0;
      end else if (os_tick) begin
         seen_ct <= (seen_ct == CT_W'(OVS - 1)) ? '0 : seen_ct + CT_W'(1);
      end
   end

   // R1
   quiet_in_reset_chk: assert property (@(posedge clk)
      (rst && rst_q) |-> (!os_tick && !bit_tick));

   // R7
   no_adjacent_tick_chk: assert property (@(posedge clk) disable iff (rst)
      os_tick |=> !os_tick);

   // R9
   bit_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
      bit_tick |-> os_tick);

   // R9
   bit_alignment_chk: assert property (@(posedge clk) disable iff (rst)
      (BIT_TICK_EN && os_tick) |-> (bit_tick == (seen_ct == CT_W'(OVS - 1))));

endmodule

bind baud_frac_tick_gen baud_frac_tick_gen_chk #(
   .OVS         (OVS),
   .BIT_TICK_EN (BIT_TICK_EN)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .os_tick  (os_tick),
   .bit_tick (bit_tick)
);

// File: tb/baud_frac_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_frac_tick_gen_tb_top;

   localparam int unsigned DIV_W  = 16;
   localparam int unsigned FRAC_W = 8;
   localparam int unsigned OVS    = 16;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [DIV_W-1:0]  div_int = 16'd13;
   logic [FRAC_W-1:0] div_frac = '0;
   logic              os_tick;
   logic              bit_tick;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   baud_frac_tick_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OVS(OVS)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .div_int  (div_int),
      .div_frac (div_frac),
      .os_tick  (os_tick),
      .bit_tick (bit_tick)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Hold reset with the given settings and check the outputs stay low (R1).
   task automatic do_reset(input int n, input int f);
      int bad = 0;
      @(negedge clk);
      rst      = 1'b1;
      div_int  = DIV_W'(n);
      div_frac = FRAC_W'(f);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (os_tick || bit_tick) bad++;
      end
      chk(bad == 0, "R1 quiet during reset", bad, 0);
      rst = 1'b0;
   endtask

   task automatic next_tick(output int c, output bit b);
      do @(negedge clk); while (!os_tick);
      c = cyc;
      b = bit_tick;
   endtask

   function automatic longint exp_time(input longint j, input longint n, input longint f);
      return j * n + (((j - 1) * f) >> FRAC_W) - 1;
   endfunction

   // General run: first strobe, exact strobe times, gap range, bit alignment.
   task automatic run_ratio(input int n, input int f, input int nbits, input string req);
      int  c, prev, gap_bad, time_bad, bit_bad, first_c, last_c;
      bit  b;
      gap_bad = 0; time_bad = 0; bit_bad = 0;
      do_reset(n, f);
      next_tick(first_c, b);
      chk(first_c == n - 1, "R2 first strobe edge", first_c, n - 1);
      prev = first_c;
      last_c = first_c;
      for (int j = 2; j <= OVS * nbits + 1; j++) begin
         next_tick(c, b);
         if (c - prev != n && c - prev != n + 1) gap_bad++;
         if (longint'(c) != exp_time(j, n, f)) time_bad++;
         if (b != ((j % OVS) == 0)) bit_bad++;
         prev = c;
         last_c = c;
      end
      chk(gap_bad == 0, "R3 gap is N or N+1", gap_bad, 0);
      chk(time_bad == 0, req, time_bad, 0);
      chk(bit_bad == 0, "R9 bit strobe alignment", bit_bad, 0);
      chk(longint'(last_c - first_c) ==
          longint'(OVS * nbits) * n + ((longint'(OVS * nbits) * f) >> FRAC_W),
          "R4 total span over bits", last_c - first_c,
          longint'(OVS * nbits) * n + ((longint'(OVS * nbits) * f) >> FRAC_W));
   endtask

   task automatic t_integer;
      int c, prev, bad;
      bit b;
      run_ratio(27, 0, 2, "R6 integer divisor strobe times");
      do_reset(34, 0);
      next_tick(prev, b);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         next_tick(c, b);
         if (c - prev != 34) bad++;
         prev = c;
      end
      chk(bad == 0, "R6 constant gap of 34", bad, 0);
   endtask

   task automatic t_alternate;
      int c, prev, bad;
      bit b;
      do_reset(13, 1 << (FRAC_W - 1));
      next_tick(prev, b);
      chk(prev == 12, "R5 first strobe", prev, 12);
      bad = 0;
      for (int i = 0; i < 32; i++) begin
         next_tick(c, b);
         if (c - prev != ((i % 2 == 0) ? 13 : 14)) bad++;
         prev = c;
      end
      chk(bad == 0, "R5 alternating 13/14 gaps", bad, 0);
   endtask

   task automatic t_clamp;
      int c1, c2;
      bit b;
      do_reset(1, 0);
      next_tick(c1, b);
      next_tick(c2, b);
      chk(c1 == 1, "R7 divisor 1 first strobe", c1, 1);
      chk(c2 - c1 == 2, "R7 divisor 1 gap", c2 - c1, 2);
      do_reset(0, 0);
      next_tick(c1, b);
      next_tick(c2, b);
      chk(c2 - c1 == 2, "R7 divisor 0 gap", c2 - c1, 2);
   endtask

   task automatic t_change;
      int c1, c2, c3, c4;
      bit b;
      do_reset(20, 0);
      next_tick(c1, b);
      next_tick(c2, b);
      repeat (5) @(negedge clk);
      div_int  = DIV_W'(6);
      div_frac = FRAC_W'(200);
      next_tick(c3, b);
      next_tick(c4, b);
      chk(c3 - c2 == 20, "R8 current interval kept", c3 - c2, 20);
      chk(c4 - c3 == 6, "R8 new divisor next interval", c4 - c3, 6);
   endtask

   task automatic t_mid_reset;
      int c, prev;
      bit b;
      do_reset(13, 1 << (FRAC_W - 1));
      for (int i = 0; i < 3; i++) next_tick(c, b);
      repeat (4) @(negedge clk);
      do_reset(13, 1 << (FRAC_W - 1));
      next_tick(prev, b);
      chk(prev == 12, "R2 first strobe after mid-run reset", prev, 12);
      next_tick(c, b);
      chk(c - prev == 13, "R1 accumulator cleared by reset", c - prev, 13);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      do_reset(13, 0);
      chk(os_tick == 1'b0 && bit_tick == 1'b0, "R1 outputs low at reset exit",
          {os_tick, bit_tick}, 0);
      t_integer();
      t_alternate();
      run_ratio(33, 232, 2, "R4 strobe times 33+232/256");
      run_ratio(13, 144, 4, "R4 strobe times 13+144/256");
      run_ratio(5, 1, 17, "R4 strobe times 5+1/256");
      t_clamp();
      t_change();
      t_mid_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule